// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 512Ki words by 8 bits. The host hands over one access at a time through a valid/ready request port that carries a 19-bit word address, an 8-bit write value and a direction flag. The controller then sequences the active-low chip-select, read-strobe and write-strobe lines and the data bus, and for a read it returns the fetched byte with a one-cycle valid pulse.

Each phase of an access lasts a whole number of clock cycles. The count for each phase is derived at elaboration from the clock period and the memory's nanosecond limits, rounded up, never less than one cycle. The data bus appears as a pad-ready split: an outgoing value, a drive enable and an incoming value. The controller drives the bus only inside the write strobe window and the cycle that follows it. The read strobe is never low while the bus is driven.

The state machine has five states. IDLE accepts a request: a write moves to WSETUP, a read moves to RACCESS. WSETUP (chip select low, bus released, for the bus-release time) moves to WPULSE once its count expires. WPULSE (write strobe low, bus driven) moves to WHOLD once its count expires. WHOLD (write strobe back high, address and data held) returns to IDLE after one cycle. RACCESS (chip select and read strobe low) samples the bus on its last cycle and returns to IDLE.

Top module: `asram_access_ctrl`

## Requirements
- R1: During and immediately after synchronous reset, chip select, read strobe and write strobe are high, the bus drive enable is low, request ready is high and read valid is low.
- R2: Request ready is high only in IDLE. A request is taken at the clock edge where request valid and ready are both high. Ready stays low from that edge until the access has finished.
- R3: A read holds chip select and read strobe low with the write strobe high for exactly N_RD cycles, starting in the cycle after acceptance, and presents the requested address throughout.
- R4: The bus input is sampled at the end of the last read cycle. Read valid is high for exactly the following cycle and carries that sampled byte.
- R5: A write holds chip select low for N_SU + N_WE + 1 cycles: first N_SU cycles with the write strobe high, then N_WE cycles with it low, then one cycle with it high again. The read strobe stays high throughout.
- R6: The bus drive enable is high exactly during the write-strobe-low cycles and the single cycle after them, and the outgoing data equals the request's write byte. Address and data do not change on the cycle where the write strobe rises.
- R7: The write strobe is never low unless chip select is low and the read strobe is high. Chip select is high whenever no access is in progress.
- R8: Between two accesses at least one cycle has all three strobes high and the bus released. The read strobe never falls while the bus is driven or in the cycle right after it was driven.
- R9: With limits T ns and clock period P ns, a phase lasts ceil(T/P) cycles, at least 1. N_SU comes from the 15 ns bus-release limit. N_RD is the largest of the 45 ns address access, 20 ns strobe access and 45 ns cycle limits. N_WE is the largest of the 35 ns strobe width, the 25 ns data setup, and the 45 ns cycle count minus N_SU+1. At 10 ns this gives N_SU=2, N_WE=4, N_RD=5.
- R10: Changes on the request address, write data or direction inputs while an access is in progress have no effect on the memory-side address or data of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle pulse: read byte available |
| rd_data | output | 8 | Read byte |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Value seen on the data bus |

## Verification
Every cycle, the assertions check the strobe encoding, the absence of bus contention with the read strobe, and the address being held while chip select is low. They also check that the write edge has stable address and data, the minimum strobe widths, the single-cycle read-valid pulse and the idle gap before a read strobe. Only the bench scenarios can show exact phase lengths against the derived counts and that the byte returned is the one stored at that address. They also show that sampling happens on the last read cycle and not earlier, since the memory model returns junk until the access time has elapsed, and that request inputs changed mid-access leave the memory side untouched.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACCESS
    } asram_state_e;

    // Whole cycles covering a nanosecond limit, never fewer than one.
    function automatic int ns_to_cycles(input int limit_ns, input int period_ns);
        int c;
        c = (limit_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (!expired)
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/asram_req_latch.sv
module asram_req_latch #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (take) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end
endmodule

// File: rtl/asram_read_capture.sv
module asram_read_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample,
    input  logic [DW-1:0] bus_in,
    output logic          valid_q,
    output logic [DW-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= sample;
            if (sample)
                data_q <= bus_in;
        end
    end

    // R4
    rd_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);
endmodule

// File: rtl/asram_access_ctrl.sv
module asram_access_ctrl
    import asram_pkg::*;
#(
    parameter int AW                = 19,
    parameter int DW                = 8,
    parameter int CLK_PERIOD_NS     = 10,
    parameter int T_BUS_RELEASE_NS  = 15,
    parameter int T_ADDR_ACCESS_NS  = 45,
    parameter int T_STROBE_ACC_NS   = 20,
    parameter int T_READ_CYCLE_NS   = 45,
    parameter int T_WE_WIDTH_NS     = 35,
    parameter int T_DATA_SETUP_NS   = 25,
    parameter int T_WRITE_CYCLE_NS  = 45
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    // R9: phase lengths in cycles
    localparam int N_SU = ns_to_cycles(T_BUS_RELEASE_NS, CLK_PERIOD_NS);
    localparam int N_RD = imax(imax(ns_to_cycles(T_ADDR_ACCESS_NS, CLK_PERIOD_NS),
                                    ns_to_cycles(T_STROBE_ACC_NS, CLK_PERIOD_NS)),
                               ns_to_cycles(T_READ_CYCLE_NS, CLK_PERIOD_NS));
    localparam int N_WE = imax(imax(ns_to_cycles(T_WE_WIDTH_NS, CLK_PERIOD_NS),
                                    ns_to_cycles(T_DATA_SETUP_NS, CLK_PERIOD_NS)),
                               ns_to_cycles(T_WRITE_CYCLE_NS, CLK_PERIOD_NS) - N_SU - 1);
    localparam int N_MAX = imax(N_RD, imax(N_SU, N_WE));
    localparam int CNT_W = $clog2(N_MAX + 1);
    localparam logic [CNT_W-1:0] SU_LAST = CNT_W'(N_SU - 1);
    localparam logic [CNT_W-1:0] WE_LAST = CNT_W'(N_WE - 1);
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(N_RD - 1);

    asram_state_e     state_q, state_d;
    logic             tmr_load, tmr_expired, take, sample;
    logic [CNT_W-1:0] tmr_val;

    asram_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
    );

    asram_req_latch #(.AW(AW), .DW(DW)) latch_i (
        .clk(clk), .rst(rst), .take(take), .addr_in(req_addr), .data_in(req_wdata),
        .addr_q(mem_addr), .data_q(mem_dq_out)
    );

    asram_read_capture #(.DW(DW)) capture_i (
        .clk(clk), .rst(rst), .sample(sample), .bus_in(mem_dq_in),
        .valid_q(rd_valid), .data_q(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and phase timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        take     = 1'b0;
        sample   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    take     = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WSETUP;
                        tmr_val = SU_LAST;
                    end else begin
                        state_d = ST_RACCESS;
                        tmr_val = RD_LAST;
                    end
                end
            end
            ST_WSETUP: begin
                if (tmr_expired) begin
                    state_d  = ST_WPULSE;
                    tmr_load = 1'b1;
                    tmr_val  = WE_LAST;
                end
            end
            ST_WPULSE: begin
                if (tmr_expired)
                    state_d = ST_WHOLD;
            end
            ST_WHOLD: state_d = ST_IDLE;
            ST_RACCESS: begin
                if (tmr_expired) begin
                    sample  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Strobes and bus enable per state
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_WSETUP:  mem_ce_n  = 1'b0;
            ST_WPULSE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WHOLD: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_RACCESS: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            default: req_ready = 1'b0;
        endcase
    end

    // Checker state: run lengths of the strobes
    logic [7:0] we_run_q, oe_run_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            we_run_q <= '0;
            oe_run_q <= '0;
        end else begin
            we_run_q <= mem_we_n ? 8'd0 : ((we_run_q == 8'hFF) ? we_run_q : we_run_q + 8'd1);
            oe_run_q <= mem_oe_n ? 8'd0 : ((oe_run_q == 8'hFF) ? oe_run_q : oe_run_q + 8'd1);
        end
    end

    // R7
    we_encoding_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));
    // R8
    bus_contention_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);
    // R8
    oe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));
    // R2
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> !req_ready);
    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
    // R6
    write_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe && !mem_ce_n));
    // R5
    we_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (int'(we_run_q) >= N_WE));
    // R3
    oe_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (int'(oe_run_q) >= N_RD));
    // R4
    rd_after_oe_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!mem_oe_n));
endmodule

// File: tb/asram_access_ctrl_tb_top.sv
module asram_access_ctrl_tb_top;
    localparam int PER = 10;
    // R9: counts derived in the bench from the limits
    localparam int SU = (15 + PER - 1) / PER;
    localparam int WE_A = (35 + PER - 1) / PER;
    localparam int WE_B = ((45 + PER - 1) / PER) - SU - 1;
    localparam int WE = (WE_A > WE_B) ? WE_A : WE_B;
    localparam int RD = (45 + PER - 1) / PER;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  rd_data, mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hA5;
    logic [18:0] mem_addr;

    int checks = 0, errors = 0;
    int kq[$];
    logic [7:0]  mem_m [int];
    logic [18:0] cur_addr;
    logic [7:0]  cur_wdata, exp_rd;
    bit run = 0, rv_pend = 0, we_prev = 1, finished = 0;
    int rd_k = 0;

    always #(PER/2) clk = ~clk;

    asram_access_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    function automatic logic [7:0] mem_read(input logic [18:0] a);
        if (mem_m.exists(int'(a))) return mem_m[int'(a)];
        return a[7:0] ^ 8'h3C;
    endfunction

    // kind: 0 idle, 1 write setup, 2 write pulse, 3 write hold, 4 read, 5 last read
    function automatic logic [3:0] strobes(input int k);
        case (k)
            1: return 4'b0110;
            2: return 4'b0101;
            3: return 4'b0111;
            4, 5: return 4'b0010;
            default: return 4'b1110;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference model, compared every cycle
    always @(negedge clk) begin
        int k;
        logic [3:0] e, a;
        if (run) begin
            k = (kq.size() > 0) ? kq.pop_front() : 0;
            e = strobes(k);
            a = {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe};
            if (k == 0)      chk(a == e, "R8 idle strobes", a, e);
            else if (k >= 4) chk(a == e, "R3 read strobes", a, e);
            else             chk(a == e, "R5 write strobes", a, e);
            chk(req_ready == (k == 0), "R2 ready", req_ready, (k == 0));
            if (k != 0) chk(mem_addr == cur_addr, "R10 address", mem_addr, cur_addr);
            if (k == 2 || k == 3) chk(mem_dq_out == cur_wdata, "R6 write data", mem_dq_out, cur_wdata);
            chk(rd_valid == rv_pend, "R4 read valid", rd_valid, rv_pend);
            if (rv_pend) chk(rd_data == exp_rd, "R4 read data", rd_data, exp_rd);
            rv_pend = (k == 5);
            if (!we_prev && mem_we_n && !mem_ce_n) mem_m[int'(mem_addr)] = mem_dq_out;
            we_prev = mem_we_n;
            if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_k++; else rd_k = 0;
            mem_dq_in = (rd_k * PER >= 45) ? mem_read(mem_addr) : 8'hA5;
            if (k == 0 && req_valid) begin
                cur_addr = req_addr;
                if (req_write) begin
                    cur_wdata = req_wdata;
                    for (int i = 0; i < SU; i++) kq.push_back(1);
                    for (int i = 0; i < WE; i++) kq.push_back(2);
                    kq.push_back(3);
                end else begin
                    exp_rd = mem_read(req_addr);
                    for (int i = 0; i < RD - 1; i++) kq.push_back(4);
                    kq.push_back(5);
                end
            end
        end
    end

    task automatic issue(input bit w, input logic [18:0] a, input logic [7:0] d);
        bit ok;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        forever begin
            @(negedge clk); ok = req_ready;
            @(posedge clk); #2;
            if (ok) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic settle();
        while (kq.size() > 0 || rv_pend) @(posedge clk);
        repeat (2) @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe} == 4'b1110, "R1 strobes in reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
        chk(req_ready && !rd_valid, "R1 ready/valid in reset", {req_ready, rd_valid}, 2'b10);
        @(posedge clk); #2; rst = 1'b0; run = 1;

        issue(1, 19'h00010, 8'h5A);       // R5 R6 plain write
        issue(0, 19'h00010, 8'h00);       // R3 R4 read back, write-to-read gap R8
        settle();
        issue(1, 19'h7FFFF, 8'hC3);       // top address
        issue(1, 19'h00000, 8'h81);       // back-to-back writes
        issue(0, 19'h7FFFF, 8'h00);
        issue(0, 19'h00000, 8'h00);       // back-to-back reads
        issue(0, 19'h12345, 8'h00);       // never written
        settle();
        // R10: request inputs change mid-access
        issue(0, 19'h00010, 8'h00);
        req_addr = 19'h55555; req_wdata = 8'hFF; req_write = 1'b1;
        repeat (3) @(posedge clk); #2;
        issue(1, 19'h2AAAA, 8'h3E);
        req_addr = 19'h0F0F0; req_wdata = 8'h11;
        repeat (2) @(posedge clk); #2;
        issue(0, 19'h2AAAA, 8'h00);
        issue(1, 19'h00010, 8'h77);       // read-to-write
        issue(0, 19'h00010, 8'h00);
        settle();
        run = 0;
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule